// File: doc/BRIEF.md
# Sixteen-Bit Accumulator Processor Core

This core executes a compact instruction set built around a single 16-bit accumulator and a 12-bit program counter. Every instruction is one 16-bit word: a 4-bit opcode on top and a 12-bit field below. The field is either a signed immediate value or a word address. The core can load a value into the accumulator in immediate, direct or indirect mode. It can store the accumulator directly or through a pointer word, add a memory word to the accumulator, and negate the accumulator. It can branch unconditionally or on the sign of the accumulator, and it can halt.

The core reaches memory through one single-port word bus. The bus has an enable, a direction line (1 for read, 0 for write), a 12-bit address, a write-data word and a read-data word. The memory answers within the same cycle. A multi-cycle sequencer steps through fetch, decode, an optional pointer read and one operand access. The accumulator, the program counter and a halted flag are visible as outputs, so a system can observe progress.

Top module: `accum_cpu`

## Requirements
- R1: An active-low asynchronous reset clears the program counter and the accumulator to 0 and deasserts the halted flag at once. Release is synchronised over two clock edges. The third rising edge after release completes the fetch of address 0.
- R2: Each instruction starts with a fetch cycle: enable high, direction 1, address equal to the program counter. The program counter then increments by one. The next cycle is a decode cycle with the enable low. The opcode is bits 15:12 and the field is bits 11:0.
- R3: Opcode 0x1 loads the field, sign-extended from 12 to 16 bits, into the accumulator. The instruction takes two cycles, so 0xFFF yields 0xFFFF.
- R4: Opcode 0x2 loads the word at the field address, and opcode 0xA adds that word to the accumulator modulo 2^16. Each takes three cycles, with the read in the third.
- R5: Opcodes 0x3 (load) and 0x5 (store) are indirect. The third cycle reads a pointer word at the field address. The fourth cycle reads or writes the word whose address is the low 12 bits of that pointer.
- R6: Opcode 0x4 writes the accumulator to the field address in its third cycle, with enable high, direction 0 and write data equal to the accumulator.
- R7: Opcode 0x6 always branches. Opcodes 0x7, 0x8 and 0x9 branch only if the accumulator is zero, greater than zero as a signed value, or negative. A taken branch loads the field into the program counter at the end of the decode cycle; an untaken branch leaves the incremented value.
- R8: The word 0x0001 replaces the accumulator with its two's-complement negation in two cycles. 0x8000 maps to itself.
- R9: The word 0x0000 raises the halted flag at the end of its decode cycle. From then until reset the enable stays low and the program counter and accumulator hold.
- R10: All other words are no-ops: opcodes 0xB to 0xF, and opcode 0x0 with any field other than 0 or 1. Each takes two cycles with no bus access and leaves the accumulator unchanged.
- R11: A cycle that writes memory is always followed by a fetch read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | output | 1 | Memory access strobe |
| mem_rd | output | 1 | Access direction, 1 = read, 0 = write |
| mem_addr | output | 12 | Word address |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_rdata | input | 16 | Read data, valid in the same cycle |
| halted | output | 1 | Core has executed a halt |
| acc_value | output | 16 | Accumulator contents |
| pc_value | output | 12 | Program counter contents |

## Verification
The bench goes after the following corner cases. Sign extension of a 12-bit immediate with its top bit set: a core that zero-extends loads 0x0FFF instead of 0xFFFF. Negation of 0x8000. The zero/positive/negative branch tests with the accumulator exactly at zero: a core that treats zero as positive takes a branch it must skip. Indirect access: a core that skips the pointer cycle writes or reads the pointer slot itself. Addresses above the 64-word model memory exercise the aliasing of the upper field bits. Halt and the unused encodings are checked for staying off the bus. A reset asserted in mid-program must clear the state at once.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;

  // Opcode nibble width; the field width follows from the word width.
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LDI  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_LD   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_LDX  = 4'h3;
  localparam logic [OPC_W-1:0] OPC_ST   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_STX  = 4'h5;
  localparam logic [OPC_W-1:0] OPC_JMP  = 4'h6;
  localparam logic [OPC_W-1:0] OPC_JZ   = 4'h7;
  localparam logic [OPC_W-1:0] OPC_JP   = 4'h8;
  localparam logic [OPC_W-1:0] OPC_JN   = 4'h9;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'hA;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_PTR,
    ST_MEM,
    ST_HALT
  } state_e;

  typedef enum logic [3:0] {
    K_NOP,
    K_HALT,
    K_NEG,
    K_LDI,
    K_LD,
    K_LDX,
    K_ST,
    K_STX,
    K_ADD,
    K_BR
  } kind_e;

  typedef enum logic [1:0] {
    C_ALWAYS,
    C_ZERO,
    C_POS,
    C_NEG
  } cond_e;

  typedef enum logic [1:0] {
    A_SEXT,
    A_NEG,
    A_PASS,
    A_ADD
  } alu_e;

endpackage

// File: rtl/acc_rst_sync.sv
`timescale 1ns/1ps
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_decode.sv
`timescale 1ns/1ps
module acc_decode
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] instr,
  output kind_e             kind,
  output cond_e             cond,
  output alu_e              alu_sel,
  output logic              mem_phase,
  output logic              indirect,
  output logic              is_store
);

  localparam logic [DATA_W-1:0] WORD_HALT = '0;
  localparam logic [DATA_W-1:0] WORD_NEG  = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [OPC_W-1:0] opc;
  assign opc = instr[DATA_W-1 -: OPC_W];

  always_comb begin
    kind    = K_NOP;
    cond    = C_ALWAYS;
    alu_sel = A_PASS;
    if (instr == WORD_HALT) begin
      kind = K_HALT;
    end else if (instr == WORD_NEG) begin
      kind    = K_NEG;
      alu_sel = A_NEG;
    end else begin
      case (opc)
        OPC_LDI: begin kind = K_LDI; alu_sel = A_SEXT; end
        OPC_LD:  kind = K_LD;
        OPC_LDX: kind = K_LDX;
        OPC_ST:  kind = K_ST;
        OPC_STX: kind = K_STX;
        OPC_ADD: begin kind = K_ADD; alu_sel = A_ADD; end
        OPC_JMP: begin kind = K_BR; cond = C_ALWAYS; end
        OPC_JZ:  begin kind = K_BR; cond = C_ZERO;   end
        OPC_JP:  begin kind = K_BR; cond = C_POS;    end
        OPC_JN:  begin kind = K_BR; cond = C_NEG;    end
        default: kind = K_NOP;
      endcase
    end
  end

  assign mem_phase = (kind == K_LD) || (kind == K_LDX) || (kind == K_ST) ||
                     (kind == K_STX) || (kind == K_ADD);
  assign indirect  = (kind == K_LDX) || (kind == K_STX);
  assign is_store  = (kind == K_ST) || (kind == K_STX);

endmodule

// File: rtl/acc_cond.sv
`timescale 1ns/1ps
module acc_cond
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  cond_e             cond,
  output logic              taken
);

  logic is_zero;
  logic is_neg;

  assign is_zero = (acc == '0);
  assign is_neg  = acc[DATA_W-1];

  always_comb begin
    case (cond)
      C_ZERO:  taken = is_zero;
      C_POS:   taken = !is_zero && !is_neg;
      C_NEG:   taken = is_neg;
      default: taken = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLD_W  = 12
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [FLD_W-1:0]  field,
  input  logic [DATA_W-1:0] rdata,
  input  alu_e              sel,
  output logic [DATA_W-1:0] result
);

  localparam int EXT_W = DATA_W - FLD_W;

  always_comb begin
    case (sel)
      A_SEXT:  result = {{EXT_W{field[FLD_W-1]}}, field};
      A_NEG:   result = '0 - acc;
      A_ADD:   result = acc + rdata;
      default: result = rdata;
    endcase
  end

endmodule

// File: rtl/accum_cpu.sv
`timescale 1ns/1ps
module accum_cpu
  import acc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RST_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    mem_en,
  output logic                    mem_rd,
  output logic [DATA_W-OPC_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    halted,
  output logic [DATA_W-1:0]       acc_value,
  output logic [DATA_W-OPC_W-1:0] pc_value
);

  localparam int FLD_W = DATA_W - OPC_W;

  logic srst_n;

  state_e             state_q, state_nxt;
  logic [FLD_W-1:0]   pc_q, pc_nxt;
  logic [DATA_W-1:0]  ir_q;
  logic [FLD_W-1:0]   ea_q, ea_nxt;
  logic [DATA_W-1:0]  acc_q;
  logic [DATA_W-1:0]  acc_nxt;
  logic               pc_en, ir_en, ea_en, acc_en;

  kind_e              kind;
  cond_e              cond;
  alu_e               alu_sel;
  logic               mem_phase, indirect, is_store;
  logic               br_taken;
  logic [FLD_W-1:0]   field;

  acc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  acc_decode #(.DATA_W(DATA_W)) u_decode (
    .instr     (ir_q),
    .kind      (kind),
    .cond      (cond),
    .alu_sel   (alu_sel),
    .mem_phase (mem_phase),
    .indirect  (indirect),
    .is_store  (is_store)
  );

  acc_cond #(.DATA_W(DATA_W)) u_cond (
    .acc   (acc_q),
    .cond  (cond),
    .taken (br_taken)
  );

  assign field = ir_q[FLD_W-1:0];

  acc_alu #(.DATA_W(DATA_W), .FLD_W(FLD_W)) u_alu (
    .acc    (acc_q),
    .field  (field),
    .rdata  (mem_rdata),
    .sel    (alu_sel),
    .result (acc_nxt)
  );

  // Sequencer: next state
  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_FETCH:  state_nxt = ST_DECODE;
      ST_DECODE: begin
        if (kind == K_HALT)  state_nxt = ST_HALT;
        else if (mem_phase)  state_nxt = indirect ? ST_PTR : ST_MEM;
        else                 state_nxt = ST_FETCH;
      end
      ST_PTR:    state_nxt = ST_MEM;
      ST_MEM:    state_nxt = ST_FETCH;
      ST_HALT:   state_nxt = ST_HALT;
      default:   state_nxt = ST_FETCH;
    endcase
  end

  // Register enables and next values
  always_comb begin
    ir_en  = (state_q == ST_FETCH);
    pc_en  = (state_q == ST_FETCH) ||
             ((state_q == ST_DECODE) && (kind == K_BR) && br_taken);
    pc_nxt = (state_q == ST_FETCH) ? pc_q + FLD_W'(1) : field;
    ea_en  = (state_q == ST_DECODE) || (state_q == ST_PTR);
    ea_nxt = (state_q == ST_PTR) ? mem_rdata[FLD_W-1:0] : field;
    acc_en = ((state_q == ST_DECODE) && ((kind == K_LDI) || (kind == K_NEG))) ||
             ((state_q == ST_MEM) &&
              ((kind == K_LD) || (kind == K_LDX) || (kind == K_ADD)));
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      ea_q    <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_nxt;
      if (pc_en)  pc_q  <= pc_nxt;
      if (ir_en)  ir_q  <= mem_rdata;
      if (ea_en)  ea_q  <= ea_nxt;
      if (acc_en) acc_q <= acc_nxt;
    end
  end

  // Bus drive
  always_comb begin
    mem_en   = 1'b0;
    mem_rd   = 1'b1;
    mem_addr = pc_q;
    case (state_q)
      ST_FETCH: begin
        mem_en   = 1'b1;
        mem_addr = pc_q;
      end
      ST_PTR: begin
        mem_en   = 1'b1;
        mem_addr = ea_q;
      end
      ST_MEM: begin
        mem_en   = 1'b1;
        mem_rd   = !is_store;
        mem_addr = ea_q;
      end
      default: begin
        mem_en = 1'b0;
      end
    endcase
  end

  assign mem_wdata = acc_q;
  assign halted    = (state_q == ST_HALT);
  assign acc_value = acc_q;
  assign pc_value  = pc_q;

endmodule

// File: rtl/acc_core_chk.sv
`timescale 1ns/1ps
module acc_core_chk #(
  parameter int DATA_W = 16,
  parameter int FLD_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic              mem_rd,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              halted,
  input logic [DATA_W-1:0] acc_value,
  input logic [FLD_W-1:0]  pc_value
);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9
  halt_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_en);

  // R9
  halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc_value) && $stable(acc_value)));

  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_rd) |-> (mem_wdata == acc_value));

  // R11
  write_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_rd) |=> (mem_en && mem_rd));

  // R6
  store_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_rd) |=> $stable(acc_value));

endmodule

bind accum_cpu acc_core_chk #(.DATA_W(DATA_W), .FLD_W(FLD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_en    (mem_en),
  .mem_rd    (mem_rd),
  .mem_wdata (mem_wdata),
  .halted    (halted),
  .acc_value (acc_value),
  .pc_value  (pc_value)
);

// File: tb/accum_cpu_bench.sv
`timescale 1ns/1ps
module accum_cpu_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_en, mem_rd, halted;
  logic [11:0] mem_addr, pc_value;
  logic [15:0] mem_wdata, mem_rdata, acc_value;

  logic [15:0] ram   [64];
  logic [15:0] mem_m [64];
  logic [11:0] m_pc;
  logic [15:0] m_acc;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  accum_cpu u_accum_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_en    (mem_en),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted),
    .acc_value (acc_value),
    .pc_value  (pc_value)
  );

  // 64-word model memory, low 6 address bits only, same-cycle read
  assign mem_rdata = ram[mem_addr[5:0]];
  always @(posedge clk) if (mem_en && !mem_rd) ram[mem_addr[5:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] w);
    ram[a]   = w;
    mem_m[a] = w;
  endtask

  task automatic load_prog(input int id);
    for (int i = 0; i < 64; i++) put(i, 16'h0000);
    case (id)
      1: begin
        put(0, 16'h1FFF);  put(1, 16'h4030);  put(2, 16'h0001);  put(3, 16'h2031);
        put(4, 16'hA032);  put(5, 16'h5033);  put(6, 16'h3035);  put(7, 16'h7009);
        put(9, 16'h9008);  put(10, 16'h8008); put(11, 16'h17FF); put(12, 16'h800E);
        put(14, 16'h700D); put(15, 16'h0001); put(16, 16'h9012); put(18, 16'h6014);
        put(20, 16'hB123); put(21, 16'hFFFF); put(22, 16'h0005);
        put(48, 16'h7777); put(49, 16'h1234); put(50, 16'h8000); put(51, 16'h0034);
        put(53, 16'h0036); put(54, 16'h0000);
      end
      2: begin
        put(0, 16'h1000);  put(1, 16'h40A0);  put(2, 16'h2021);  put(3, 16'h700C);
        put(4, 16'hA022);  put(5, 16'h4021);  put(6, 16'h2020);  put(7, 16'hA023);
        put(8, 16'h4020);  put(9, 16'h6002);  put(12, 16'h2020);
        put(32, 16'h5555); put(33, 16'h0005); put(34, 16'hFFFF); put(35, 16'h0100);
      end
      default: begin
        put(0, 16'h2010);  put(1, 16'h0001);  put(2, 16'h8004);  put(3, 16'h9005);
        put(5, 16'h1800);  put(16, 16'h8000);
      end
    endcase
  endtask

  task automatic do_reset(input int id);
    rst_n = 1'b0;
    @(negedge clk);
    load_prog(id);
    // R1 reset state
    chk(pc_value === 12'h000, "R1", "pc in reset", pc_value, 0);
    chk(acc_value === 16'h0000, "R1", "acc in reset", acc_value, 0);
    chk(halted === 1'b0, "R1", "halted in reset", halted, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(mem_addr === 12'h000, "R1", "first fetch address", mem_addr, 0);
    m_pc  = '0;
    m_acc = '0;
  endtask

  task automatic check_regs(input string t);
    chk(acc_value === m_acc, t, "accumulator", acc_value, m_acc);
    chk(pc_value === m_pc, t, "program counter", pc_value, m_pc);
    chk(halted === 1'b0, t, "halted low", halted, 0);
  endtask

  // Executes one instruction; entered and left at the negedge of a fetch cycle.
  task automatic step(output bit done);
    logic [15:0] w, opnd;
    logic [3:0]  op;
    logic [11:0] f, ea;
    string       t;
    done = 1'b0;
    w  = mem_m[m_pc[5:0]];
    op = w[15:12];
    f  = w[11:0];
    t  = "R10";
    chk(mem_en === 1'b1 && mem_rd === 1'b1, "R2", "fetch strobe", {mem_en, mem_rd}, 2'b11);
    chk(mem_addr === m_pc, "R2", "fetch address", mem_addr, m_pc);
    @(posedge clk); @(negedge clk);
    m_pc = m_pc + 12'd1;
    chk(pc_value === m_pc, "R2", "pc after fetch", pc_value, m_pc);
    chk(mem_en === 1'b0, "R2", "decode bus idle", mem_en, 0);
    if (w == 16'h0000) begin
      @(posedge clk); @(negedge clk);
      chk(halted === 1'b1, "R9", "halted raised", halted, 1);
      chk(pc_value === m_pc, "R9", "pc at halt", pc_value, m_pc);
      chk(acc_value === m_acc, "R9", "acc at halt", acc_value, m_acc);
      done = 1'b1;
      return;
    end
    if (w == 16'h0001) begin
      t = "R8";
      m_acc = 16'h0000 - m_acc;
    end else if (op == 4'h2 || op == 4'h3 || op == 4'h4 || op == 4'h5 || op == 4'hA) begin
      t  = (op == 4'h3 || op == 4'h5) ? "R5" : (op == 4'h4) ? "R6" : "R4";
      ea = f;
      @(posedge clk); @(negedge clk);
      if (op == 4'h3 || op == 4'h5) begin
        chk(mem_en === 1'b1 && mem_rd === 1'b1, "R5", "pointer read strobe", {mem_en, mem_rd}, 2'b11);
        chk(mem_addr === f, "R5", "pointer address", mem_addr, f);
        opnd = mem_m[f[5:0]];
        ea   = opnd[11:0];
        @(posedge clk); @(negedge clk);
      end
      if (op == 4'h4 || op == 4'h5) begin
        chk(mem_en === 1'b1 && mem_rd === 1'b0, t, "write strobe", {mem_en, mem_rd}, 2'b10);
        chk(mem_addr === ea, t, "write address", mem_addr, ea);
        chk(mem_wdata === m_acc, t, "write data", mem_wdata, m_acc);
        mem_m[ea[5:0]] = m_acc;
      end else begin
        chk(mem_en === 1'b1 && mem_rd === 1'b1, t, "operand read strobe", {mem_en, mem_rd}, 2'b11);
        chk(mem_addr === ea, t, "operand address", mem_addr, ea);
        opnd  = mem_m[ea[5:0]];
        m_acc = (op == 4'hA) ? m_acc + opnd : opnd;
      end
    end else begin
      case (op)
        4'h1: begin t = "R3"; m_acc = {{4{f[11]}}, f}; end
        4'h6: begin t = "R7"; m_pc = f; end
        4'h7: begin t = "R7"; if (m_acc == 16'h0000) m_pc = f; end
        4'h8: begin t = "R7"; if ($signed(m_acc) > 0) m_pc = f; end
        4'h9: begin t = "R7"; if (m_acc[15]) m_pc = f; end
        default: t = "R10";
      endcase
    end
    @(posedge clk); @(negedge clk);
    check_regs(t);
  endtask

  task automatic run_prog(input int id);
    bit done;
    logic [11:0] pc_hold;
    do_reset(id);
    done = 1'b0;
    for (int i = 0; i < 400 && !done; i++) step(done);
    chk(done, "R9", "program reached halt", done, 1);
    pc_hold = pc_value;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(halted === 1'b1 && mem_en === 1'b0, "R9", "halt holds, bus idle", {halted, mem_en}, 2'b10);
      chk(pc_value === pc_hold, "R9", "pc frozen", pc_value, pc_hold);
    end
    for (int a = 0; a < 64; a++)
      chk(ram[a] === mem_m[a], "R6", "memory image word", ram[a], mem_m[a]);
  endtask

  initial begin
    bit done;
    rst_n = 1'b0;
    run_prog(1);
    chk(acc_value === 16'hF801, "R8", "program 1 final acc", acc_value, 16'hF801);
    run_prog(2);
    chk(ram[32] === 16'h0500, "R4", "aliased sum word", ram[32], 16'h0500);
    run_prog(3);
    chk(acc_value === 16'hF800, "R3", "program 3 final acc", acc_value, 16'hF800);
    // R1 reset in mid-program clears state immediately
    do_reset(2);
    for (int i = 0; i < 6; i++) step(done);
    rst_n = 1'b0;
    #1;
    chk(pc_value === 12'h000, "R1", "pc after mid-run reset", pc_value, 0);
    chk(acc_value === 16'h0000, "R1", "acc after mid-run reset", acc_value, 0);
    chk(halted === 1'b0, "R1", "halted after mid-run reset", halted, 0);
    run_prog(2);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule